// File: doc/BRIEF.md
# SMRAM and TSEG access controller

This block owns the two configuration bytes that govern system-management memory in a host bridge: a control byte (open, lock, global enable) and an extended control byte (high-window enable, TSEG size code, TSEG enable). From these bytes, together with two static configuration inputs, it derives every visibility enable the memory routing fabric needs.

The first configuration input is the amount of RAM below 4 GiB, in MiB. The second is an extended TSEG size, also in MiB. The derived enables are:
- where ordinary CPU accesses to the legacy compatible window land;
- whether the high alias of that window is open to ordinary accesses;
- which copy of SMRAM an SMM access sees;
- where the TSEG carve-out at the top of low memory sits and how large it is.

Inside an active TSEG, ordinary accesses are meant to be black-holed (reads return all ones and writes are dropped), while SMM accesses reach RAM.

Firmware programs the bytes through a simple byte-write port. Setting the lock bit closes the open bit in the same update and freezes both bytes until reset. The derived outputs follow the stored bytes combinationally, so a write shows on the outputs one cycle after it is presented.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: After reset both bytes read 0, `compat_to_bus` is 1, `high_alias_en`, `smm_low_en`, `smm_high_en` and `tseg_active` are 0, `tseg_size_mb` is 0 and `tseg_base_mb` equals `low_mem_mb`.
- R2: A write with `wr_sel`=0 updates only bits 6 (open), 4 (lock) and 3 (global enable) of the control byte. A write with `wr_sel`=1 updates only bits 7 (high enable), 2:1 (size code) and 0 (TSEG enable) of the extended byte. All other bits read 0. The new value appears on the outputs in the cycle after the write.
- R3: A control-byte write that sets the lock bit clears the open bit in the same update. From then on, writes to either byte are ignored until reset.
- R4: With open=1, `compat_to_bus` and `high_alias_en` both equal the high-enable bit. With open=0, `compat_to_bus` is 1 and `high_alias_en` is 0.
- R5: `smm_low_en` = global enable AND NOT high enable. `smm_high_en` = global enable AND high enable.
- R6: When TSEG enable and global enable are both 1, `tseg_size_mb` is selected by the size code: 0 gives 1, 1 gives 2, 2 gives 8, and 3 gives `ext_tseg_mb` clamped to `EXT_MAX_MB`. Otherwise the size is 0.
- R7: `tseg_active` is 1 exactly when `tseg_size_mb` is non-zero.
- R8: `tseg_base_mb` equals `low_mem_mb - tseg_size_mb`, or 0 when the size exceeds `low_mem_mb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | 0 selects control byte, 1 selects extended byte |
| wr_data | input | 8 | Write data |
| low_mem_mb | input | MEM_MB_W | RAM below 4 GiB, MiB |
| ext_tseg_mb | input | EXT_MB_W | Extended TSEG size, MiB |
| smram_ctl | output | 8 | Stored control byte |
| smram_ext | output | 8 | Stored extended byte |
| compat_to_bus | output | 1 | Ordinary accesses to the compatible window go to the bus, not RAM |
| high_alias_en | output | 1 | High alias window open to ordinary accesses |
| smm_low_en | output | 1 | SMM accesses see SMRAM at the low window |
| smm_high_en | output | 1 | SMM accesses see SMRAM at the high alias |
| tseg_active | output | 1 | TSEG black-hole and SMM window enabled |
| tseg_base_mb | output | MEM_MB_W | TSEG base, MiB |
| tseg_size_mb | output | MEM_MB_W | TSEG size, MiB |

## Verification
The bench walks every combination of open, global enable, high enable, size code and TSEG enable, and sets reserved bits on every write. A design with a wrong write mask would echo those reserved bits. A design that swapped the window polarity would expose SMRAM to ordinary accesses while the window is closed. It sweeps the extended size across and past the clamp, and shrinks low memory below the TSEG size: a missing clamp would over-reserve, and a missing saturation would wrap the base to a huge address. Lock is exercised with open set in the same write and with later writes to both bytes. A design that kept the open bit, or left either byte writable, would leave SMRAM reachable after firmware sealed it.

// File: rtl/smram_pkg.sv
package smram_pkg;
    localparam int CTL_OPEN = 6;
    localparam int CTL_LOCK = 4;
    localparam int CTL_GEN  = 3;
    localparam int EXT_HIGH = 7;
    localparam int EXT_CODE = 1;
    localparam int EXT_TEN  = 0;

    localparam logic [7:0] CTL_WMASK     = 8'h58;
    localparam logic [7:0] CTL_WMASK_LCK = 8'h00;
    localparam logic [7:0] EXT_WMASK     = 8'h87;
    localparam logic [7:0] EXT_WMASK_LCK = 8'h00;

    typedef enum logic [1:0] {
        TSZ_1M  = 2'd0,
        TSZ_2M  = 2'd1,
        TSZ_8M  = 2'd2,
        TSZ_EXT = 2'd3
    } tseg_code_e;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] ext;
    } smram_regs_t;
endpackage

// File: rtl/smram_ctl_regs.sv
module smram_ctl_regs
    import smram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    output smram_regs_t regs_q
);
    smram_regs_t regs_d;
    logic        locked;
    logic [7:0]  ctl_mask;
    logic [7:0]  ext_mask;

    always_comb begin
        regs_d   = regs_q;
        locked   = regs_q.ctl[CTL_LOCK];
        ctl_mask = locked ? CTL_WMASK_LCK : CTL_WMASK;
        ext_mask = locked ? EXT_WMASK_LCK : EXT_WMASK;
        if (wr_en) begin
            if (!wr_sel) begin
                regs_d.ctl = (regs_q.ctl & ~ctl_mask) | (wr_data & ctl_mask);
            end else begin
                regs_d.ext = (regs_q.ext & ~ext_mask) | (wr_data & ext_mask);
            end
        end
        if (regs_d.ctl[CTL_LOCK]) begin
            regs_d.ctl[CTL_OPEN] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs_q.ctl & ~CTL_WMASK) == 8'h00) && ((regs_q.ext & ~EXT_WMASK) == 8'h00)); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctl[CTL_LOCK] |=> regs_q.ctl[CTL_LOCK]); // R3
    AST_LOCK_CLOSES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctl[CTL_LOCK] |-> !regs_q.ctl[CTL_OPEN]); // R3
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctl[CTL_LOCK] |=> $stable(regs_q)); // R3
endmodule

// File: rtl/smram_win_decode.sv
module smram_win_decode
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ctl,
    input  logic [7:0] ext,
    output logic       compat_to_bus,
    output logic       high_alias_en,
    output logic       smm_low_en,
    output logic       smm_high_en
);
    logic open_b;
    logic gen_b;
    logic high_b;

    always_comb begin
        open_b = ctl[CTL_OPEN];
        gen_b  = ctl[CTL_GEN];
        high_b = ext[EXT_HIGH];
        if (open_b) begin
            compat_to_bus = high_b;
            high_alias_en = high_b;
        end else begin
            compat_to_bus = 1'b1;
            high_alias_en = 1'b0;
        end
        smm_low_en  = gen_b & ~high_b;
        smm_high_en = gen_b &  high_b;
    end

    AST_SMM_ONE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smm_low_en, smm_high_en})); // R5
    AST_ALIAS_HIDES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        high_alias_en |-> compat_to_bus); // R4
    AST_CLOSED_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[CTL_OPEN] |-> (compat_to_bus && !high_alias_en)); // R4
endmodule

// File: rtl/tseg_carve.sv
module tseg_carve
    import smram_pkg::*;
#(
    parameter int MEM_MB_W   = 12,
    parameter int EXT_MB_W   = 12,
    parameter int EXT_MAX_MB = 4095
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_en,
    input  logic                tseg_en,
    input  tseg_code_e          code,
    input  logic [MEM_MB_W-1:0] low_mem_mb,
    input  logic [EXT_MB_W-1:0] ext_mb,
    output logic [MEM_MB_W-1:0] size_mb,
    output logic [MEM_MB_W-1:0] base_mb,
    output logic                active
);
    localparam int EXT_FULL = (1 << EXT_MB_W) - 1;
    localparam int SIZE_CAP = (EXT_MAX_MB > 8) ? EXT_MAX_MB : 8;

    logic [MEM_MB_W-1:0] ext_sz;
    logic [MEM_MB_W-1:0] sel_sz;

    generate
        if (EXT_MAX_MB < EXT_FULL) begin : g_clamp
            localparam logic [EXT_MB_W-1:0] CAP = EXT_MB_W'(EXT_MAX_MB);
            assign ext_sz = MEM_MB_W'((ext_mb > CAP) ? CAP : ext_mb);
        end else begin : g_pass
            assign ext_sz = MEM_MB_W'(ext_mb);
        end
    endgenerate

    always_comb begin
        case (code)
            TSZ_1M:  sel_sz = MEM_MB_W'(1);
            TSZ_2M:  sel_sz = MEM_MB_W'(2);
            TSZ_8M:  sel_sz = MEM_MB_W'(8);
            default: sel_sz = ext_sz;
        endcase
        size_mb = (gen_en && tseg_en) ? sel_sz : '0;
        active  = |size_mb;
        base_mb = (size_mb > low_mem_mb) ? '0 : (low_mem_mb - size_mb);
    end

    AST_TSEG_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (gen_en && tseg_en)); // R7
    AST_TSEG_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(size_mb) <= SIZE_CAP); // R6
    AST_TSEG_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (size_mb <= low_mem_mb)) |-> ((base_mb + size_mb) == low_mem_mb)); // R8
endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl
    import smram_pkg::*;
#(
    parameter int MEM_MB_W   = 12,
    parameter int EXT_MB_W   = 12,
    parameter int EXT_MAX_MB = 4095
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [7:0]          wr_data,
    input  logic [MEM_MB_W-1:0] low_mem_mb,
    input  logic [EXT_MB_W-1:0] ext_tseg_mb,
    output logic [7:0]          smram_ctl,
    output logic [7:0]          smram_ext,
    output logic                compat_to_bus,
    output logic                high_alias_en,
    output logic                smm_low_en,
    output logic                smm_high_en,
    output logic                tseg_active,
    output logic [MEM_MB_W-1:0] tseg_base_mb,
    output logic [MEM_MB_W-1:0] tseg_size_mb
);
    smram_regs_t regs_q;
    tseg_code_e  code;

    smram_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    smram_win_decode u_win (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl           (regs_q.ctl),
        .ext           (regs_q.ext),
        .compat_to_bus (compat_to_bus),
        .high_alias_en (high_alias_en),
        .smm_low_en    (smm_low_en),
        .smm_high_en   (smm_high_en)
    );

    assign code = tseg_code_e'(regs_q.ext[EXT_CODE +: 2]);

    tseg_carve #(
        .MEM_MB_W   (MEM_MB_W),
        .EXT_MB_W   (EXT_MB_W),
        .EXT_MAX_MB (EXT_MAX_MB)
    ) u_tseg (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_en     (regs_q.ctl[CTL_GEN]),
        .tseg_en    (regs_q.ext[EXT_TEN]),
        .code       (code),
        .low_mem_mb (low_mem_mb),
        .ext_mb     (ext_tseg_mb),
        .size_mb    (tseg_size_mb),
        .base_mb    (tseg_base_mb),
        .active     (tseg_active)
    );

    assign smram_ctl = regs_q.ctl;
    assign smram_ext = regs_q.ext;
endmodule

// File: tb/tb_smram_tseg_ctrl.sv
module tb_smram_tseg_ctrl;
    localparam int MW   = 12;
    localparam int EW   = 8;
    localparam int EMAX = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic [MW-1:0] low_mem_mb = 12'd2048;
    logic [EW-1:0] ext_tseg_mb = 8'd16;
    logic [7:0]    smram_ctl, smram_ext;
    logic          compat_to_bus, high_alias_en, smm_low_en, smm_high_en, tseg_active;
    logic [MW-1:0] tseg_base_mb, tseg_size_mb;

    int nchecks = 0;
    int nerr = 0;
    logic [7:0] sm_m = 8'h00;
    logic [7:0] ex_m = 8'h00;

    always #4 clk = ~clk;

    smram_tseg_ctrl #(.MEM_MB_W(MW), .EXT_MB_W(EW), .EXT_MAX_MB(EMAX)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .low_mem_mb(low_mem_mb), .ext_tseg_mb(ext_tseg_mb),
        .smram_ctl(smram_ctl), .smram_ext(smram_ext),
        .compat_to_bus(compat_to_bus), .high_alias_en(high_alias_en),
        .smm_low_en(smm_low_en), .smm_high_en(smm_high_en),
        .tseg_active(tseg_active), .tseg_base_mb(tseg_base_mb), .tseg_size_mb(tseg_size_mb)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model of a byte write: masks per R2, lock behaviour per R3
    task automatic wr(input logic sel, input logic [7:0] d);
        logic [7:0] m;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (!sel) begin
            m = sm_m[4] ? 8'h00 : 8'h58;
            sm_m = (sm_m & ~m) | (d & m);
        end else begin
            m = sm_m[4] ? 8'h00 : 8'h87;
            ex_m = (ex_m & ~m) | (d & m);
        end
        if (sm_m[4]) sm_m[6] = 1'b0;
    endtask

    function automatic int exp_size();
        int v;
        if (!(ex_m[0] && sm_m[3])) return 0;
        case (ex_m[2:1])
            2'd0: v = 1;
            2'd1: v = 2;
            2'd2: v = 8;
            default: v = (int'(ext_tseg_mb) > EMAX) ? EMAX : int'(ext_tseg_mb);
        endcase
        return v;
    endfunction

    task automatic check_all();
        int sz;
        int bs;
        sz = exp_size();
        bs = (sz > int'(low_mem_mb)) ? 0 : int'(low_mem_mb) - sz;
        chk("R2", "smram_ctl", smram_ctl, sm_m);
        chk("R2", "smram_ext", smram_ext, ex_m);
        chk("R4", "compat_to_bus", compat_to_bus, sm_m[6] ? ex_m[7] : 1'b1);
        chk("R4", "high_alias_en", high_alias_en, sm_m[6] & ex_m[7]);
        chk("R5", "smm_low_en", smm_low_en, sm_m[3] & ~ex_m[7]);
        chk("R5", "smm_high_en", smm_high_en, sm_m[3] & ex_m[7]);
        chk("R6", "tseg_size_mb", tseg_size_mb, sz);
        chk("R7", "tseg_active", tseg_active, sz != 0);
        chk("R8", "tseg_base_mb", tseg_base_mb, bs);
    endtask

    task automatic check_reset();
        chk("R1", "ctl", smram_ctl, 0);
        chk("R1", "ext", smram_ext, 0);
        chk("R1", "compat_to_bus", compat_to_bus, 1);
        chk("R1", "high_alias_en", high_alias_en, 0);
        chk("R1", "smm_low_en", smm_low_en, 0);
        chk("R1", "smm_high_en", smm_high_en, 0);
        chk("R1", "tseg_active", tseg_active, 0);
        chk("R1", "tseg_size_mb", tseg_size_mb, 0);
        chk("R1", "tseg_base_mb", tseg_base_mb, low_mem_mb);
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        nchecks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();

        // R4 R5 R6: every combination of the decoded bits, reserved bits set
        for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 16; e++) begin
                wr(1'b0, 8'hA5 | (c[1] ? 8'h40 : 8'h00) | (c[0] ? 8'h08 : 8'h00));
                wr(1'b1, 8'h78 | (e[3] ? 8'h80 : 8'h00) | {5'd0, e[2:0]});
                check_all();
            end
        end

        // R6 R8: extended size sweep through the clamp, then small low memory
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h07);
        for (int lm = 0; lm < 2; lm++) begin
            low_mem_mb = (lm == 0) ? 12'd2048 : 12'd20;
            for (int v = 0; v <= 60; v++) begin
                @(negedge clk);
                ext_tseg_mb = EW'(v);
                #1;
                check_all();
            end
        end
        low_mem_mb = 12'd1024;
        ext_tseg_mb = 8'd16;

        // R3: lock in the same write as open
        wr(1'b0, 8'h48);
        wr(1'b1, 8'h81);
        check_all();
        wr(1'b0, 8'h58);
        chk("R3", "open cleared by lock", smram_ctl, 8'h18);
        check_all();
        wr(1'b0, 8'h48);
        chk("R3", "ctl frozen", smram_ctl, 8'h18);
        wr(1'b1, 8'h06);
        chk("R3", "ext frozen", smram_ext, 8'h81);
        chk("R3", "tseg still 1M", tseg_size_mb, 1);
        check_all();

        // R1: reset releases the lock
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        sm_m = 8'h00;
        ex_m = 8'h00;
        check_reset();
        wr(1'b0, 8'h48);
        chk("R3", "writable after reset", smram_ctl, 8'h48);
        check_all();
        wr(1'b0, 8'h10);
        chk("R3", "lock alone", smram_ctl, 8'h10);
        check_all();

        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule